// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block lets CPUs signal one another through sixteen software-generated interrupts (SGIs). A CPU raises an SGI by writing a trigger word. The word carries an SGI number, a list of target CPUs and a filter mode, and the filter mode can replace the list with "everyone but me" or "only me". The block keeps a source bitmap for every target CPU and every SGI. Each bit of that bitmap records one source CPU that raised the SGI toward that target.

Two byte-per-SGI register views give each CPU access to its own bitmaps. A write to the set view ORs bits into them, and a write to the clear view removes bits. Both views read back the same bitmaps. Every access carries the ID of the requesting CPU, and that ID selects the bank of bitmaps a pending-view access touches. The pending vector output shows which SGIs are pending at each CPU. The interrupt controller's arbitration logic consumes it downstream.

Top module: `sgi_dispatch`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) empties every source bitmap. It also drops sgi_pending to all zeros and rsp_valid to 0.
- R2: Address bits 5:4 select the view: 00 trigger, 01 pending-clear, 10 pending-set, 11 unmapped. A 32-bit write to the trigger view reads three fields: SGI number from bits 3:0, target list from bits 23:16 (bit 16+t means CPU t) and mode from bits 25:24. With mode 0, every listed CPU t gets the writer's bit set in its bitmap for that SGI. The change shows on sgi_pending after the write's clock edge.
- R3: Trigger mode 1 targets every online CPU except the writer.
- R4: Trigger mode 2 targets the writer alone.
- R5: These writes change no state: a trigger write in mode 3, an 8-bit write to the trigger view, and any write to the unmapped view.
- R6: Target CPUs whose index is at or above cpus_online are dropped, in every mode, before any bitmap is updated.
- R7: A read of the trigger view or the unmapped view returns zero.
- R8: A read of a pending view returns the requester's bitmaps, one byte per SGI. An 8-bit access returns the SGI at address bits 3:0 in data bits 7:0, with bits 31:8 zero. A 32-bit access returns SGIs 4*addr[3:2] to 4*addr[3:2]+3, with the lowest SGI in bits 7:0.
- R9: A write to the pending-set view ORs each written byte into the requester's bitmap for the SGI that the byte lane selects. The lane-to-SGI mapping is the same as in R8, and an 8-bit write takes its byte from bits 7:0.
- R10: A write to the pending-clear view removes the written bits from the selected bitmaps. Lanes and bytes follow the same mapping as R9.
- R11: sgi_pending bit t*16+s is 1 exactly when the bitmap of SGI s at CPU t is non-zero.
- R12: A read request is answered one cycle later with rsp_valid high and rsp_data holding the value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpus_online | input | 4 | Number of online CPUs; higher indices cannot be targeted |
| req_valid | input | 1 | Register access this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_wide | input | 1 | 1 for a 32-bit access, 0 for an 8-bit access |
| req_addr | input | 6 | Byte offset within the block |
| req_wdata | input | 32 | Write data (8-bit writes use bits 7:0) |
| req_cpu | input | 3 | ID of the requesting CPU |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 32 | Read data |
| sgi_pending | output | 128 | Pending flags, bit t*16+s for CPU t and SGI s |

## Verification
The assertions assume the requester ID is below the CPU count. They also assume cpus_online does not change on a cycle that carries a write. The stimulus changes cpus_online only during idle cycles, and every request comes from a CPU ID of 0 to 7. The temporal checks also depend on at most one request per cycle and on set and clear never reaching the same bitmap together. The single request port guarantees both. The random phase mixes all four modes, both access widths and varying online counts, so the reserved-mode, offline-target and self-exclusion paths are all exercised.

// File: rtl/sgi_pkg.sv
// Shared definitions for the SGI dispatcher.
// Assumes a fixed 6-bit byte address space split into four 16-byte views.
package sgi_pkg;

    localparam int NUM_SGI  = 16;
    localparam int SGI_W    = 4;
    localparam int BUS_AW   = 6;
    localparam int BUS_DW   = 32;
    localparam int LANES    = BUS_DW / 8;

    // View selected by address bits 5:4
    typedef enum logic [1:0] {
        VIEW_TRIG  = 2'd0,
        VIEW_CLR   = 2'd1,
        VIEW_SET   = 2'd2,
        VIEW_NONE  = 2'd3
    } view_e;

    // Filter mode carried in the trigger word
    typedef enum logic [1:0] {
        FM_LIST    = 2'd0,
        FM_OTHERS  = 2'd1,
        FM_SELF    = 2'd2,
        FM_RSVD    = 2'd3
    } filt_e;

endpackage

// File: rtl/sgi_trigger_decode.sv
// Turns the fields of a trigger word into a target CPU mask.
// Purely combinational; assumes the writer ID is below NCPU.
module sgi_trigger_decode
    import sgi_pkg::*;
#(
    parameter int NCPU  = 8,
    parameter int ID_W  = 3,
    parameter int CNT_W = 4
) (
    input  logic [NCPU-1:0]  list_bits,
    input  logic [1:0]       mode_bits,
    input  logic [ID_W-1:0]  writer,
    input  logic [CNT_W-1:0] online,
    output logic             fire,
    output logic [NCPU-1:0]  tgt_mask
);

    logic [NCPU-1:0] online_mask;
    logic [NCPU-1:0] writer_bit;
    logic [NCPU-1:0] raw_mask;
    filt_e           mode;

    assign mode = filt_e'(mode_bits);

    // Build the online mask and the one-hot writer mask
    always_comb begin : build_masks
        for (int i = 0; i < NCPU; i++) begin
            online_mask[i] = (CNT_W'(i) < online);
            writer_bit[i]  = (ID_W'(i) == writer);
        end
    end

    // Pick the raw target set from the filter mode
    always_comb begin : pick_targets
        unique case (mode)
            FM_LIST:   raw_mask = list_bits;
            FM_OTHERS: raw_mask = ~writer_bit;
            FM_SELF:   raw_mask = writer_bit;
            default:   raw_mask = '0;
        endcase
    end

    assign fire     = (mode != FM_RSVD);
    assign tgt_mask = raw_mask & online_mask;

endmodule

// File: rtl/sgi_lane_decode.sv
// Maps the low address bits and the access width to per-lane SGI numbers.
// An 8-bit access uses lane 0 only; a 32-bit access uses an aligned group of four.
module sgi_lane_decode
    import sgi_pkg::*;
(
    input  logic [3:0]           addr_lo,
    input  logic                 wide,
    output logic [LANES-1:0]     lane_en,
    output logic [LANES*SGI_W-1:0] lane_sgi
);

    // Derive the enable and SGI number for each byte lane
    always_comb begin : lane_map
        for (int k = 0; k < LANES; k++) begin
            if (wide) begin
                lane_en[k]                = 1'b1;
                lane_sgi[k*SGI_W +: SGI_W] = {addr_lo[3:2], 2'(k)};
            end else begin
                lane_en[k]                = (k == 0);
                lane_sgi[k*SGI_W +: SGI_W] = addr_lo;
            end
        end
    end

endmodule

// File: rtl/sgi_source_bank.sv
// Source bitmaps of every SGI for one target CPU.
// Assumes set and clear never name the same bit in one cycle; clear wins if they do.
module sgi_source_bank
    import sgi_pkg::*;
#(
    parameter int NCPU = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SGI*NCPU-1:0]  set_bits,
    input  logic [NUM_SGI*NCPU-1:0]  clr_bits,
    output logic [NUM_SGI*NCPU-1:0]  src_map,
    output logic [NUM_SGI-1:0]       pend
);

    logic [NCPU-1:0] map_q [NUM_SGI];

    // Merge set and clear requests into each bitmap
    always_ff @(posedge clk) begin : map_update
        for (int s = 0; s < NUM_SGI; s++) begin
            if (!rst_n) begin
                map_q[s] <= '0;
            end else begin
                map_q[s] <= (map_q[s] | set_bits[s*NCPU +: NCPU])
                            & ~clr_bits[s*NCPU +: NCPU];
            end
        end
    end

    genvar gs;
    generate
        for (gs = 0; gs < NUM_SGI; gs++) begin : g_sgi
            assign src_map[gs*NCPU +: NCPU] = map_q[gs];
            assign pend[gs]                 = |map_q[gs];

            AST_RESET_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(rst_n) |-> (map_q[gs] == '0)); // R1

            AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_bits[gs*NCPU +: NCPU] == '0)
                |=> ((map_q[gs] & $past(set_bits[gs*NCPU +: NCPU]))
                     == $past(set_bits[gs*NCPU +: NCPU]))); // R9

            AST_FULL_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_bits[gs*NCPU +: NCPU] == '1) |=> (map_q[gs] == '0)); // R10
        end
    endgenerate

endmodule

// File: rtl/sgi_dispatch.sv
// Top of the SGI dispatcher: decodes register accesses, routes set and
// clear requests to the per-target banks and returns read data one cycle later.
// Assumes NCPU <= 8, one request per cycle and req_cpu below NCPU.
module sgi_dispatch
    import sgi_pkg::*;
#(
    parameter int NCPU  = 8,
    parameter int ID_W  = (NCPU > 1) ? $clog2(NCPU) : 1,
    parameter int CNT_W = $clog2(NCPU + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CNT_W-1:0]        cpus_online,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic                    req_wide,
    input  logic [BUS_AW-1:0]       req_addr,
    input  logic [BUS_DW-1:0]       req_wdata,
    input  logic [ID_W-1:0]         req_cpu,
    output logic                    rsp_valid,
    output logic [BUS_DW-1:0]       rsp_data,
    output logic [NCPU*NUM_SGI-1:0] sgi_pending
);

    localparam int MAP_W = NUM_SGI * NCPU;

    view_e                   view;
    logic                    trig_wr;
    logic                    set_wr;
    logic                    clr_wr;
    logic                    is_read;
    logic                    fire;
    logic [NCPU-1:0]         tgt_mask;
    logic [SGI_W-1:0]        trig_sgi;
    logic [NCPU-1:0]         writer_bit;
    logic [LANES-1:0]        lane_en;
    logic [LANES*SGI_W-1:0]  lane_sgi;
    logic [MAP_W-1:0]        set_vec  [NCPU];
    logic [MAP_W-1:0]        clr_vec  [NCPU];
    logic [MAP_W-1:0]        bank_map [NCPU];
    logic [NUM_SGI-1:0]      bank_pend[NCPU];
    logic [BUS_DW-1:0]       rd_next;

    assign view     = view_e'(req_addr[5:4]);
    assign trig_wr  = req_valid && req_write && req_wide && (view == VIEW_TRIG);
    assign set_wr   = req_valid && req_write && (view == VIEW_SET);
    assign clr_wr   = req_valid && req_write && (view == VIEW_CLR);
    assign is_read  = req_valid && !req_write;
    assign trig_sgi = req_wdata[SGI_W-1:0];

    sgi_trigger_decode #(
        .NCPU  (NCPU),
        .ID_W  (ID_W),
        .CNT_W (CNT_W)
    ) u_decode (
        .list_bits (req_wdata[16 +: NCPU]),
        .mode_bits (req_wdata[25:24]),
        .writer    (req_cpu),
        .online    (cpus_online),
        .fire      (fire),
        .tgt_mask  (tgt_mask)
    );

    sgi_lane_decode u_lanes (
        .addr_lo  (req_addr[3:0]),
        .wide     (req_wide),
        .lane_en  (lane_en),
        .lane_sgi (lane_sgi)
    );

    // One-hot mask of the writing CPU, used as the source bit
    always_comb begin : writer_onehot
        for (int i = 0; i < NCPU; i++) begin
            writer_bit[i] = (ID_W'(i) == req_cpu);
        end
    end

    // Route trigger and pending-view writes to the bitmaps they touch
    always_comb begin : route_updates
        for (int t = 0; t < NCPU; t++) begin
            set_vec[t] = '0;
            clr_vec[t] = '0;
            for (int s = 0; s < NUM_SGI; s++) begin
                if (trig_wr && fire && tgt_mask[t] && (trig_sgi == SGI_W'(s))) begin
                    set_vec[t][s*NCPU +: NCPU] = writer_bit;
                end
                if ((set_wr || clr_wr) && (req_cpu == ID_W'(t))) begin
                    for (int k = 0; k < LANES; k++) begin
                        if (lane_en[k] && (lane_sgi[k*SGI_W +: SGI_W] == SGI_W'(s))) begin
                            if (set_wr) begin
                                set_vec[t][s*NCPU +: NCPU] = set_vec[t][s*NCPU +: NCPU]
                                    | req_wdata[k*8 +: NCPU];
                            end else begin
                                clr_vec[t][s*NCPU +: NCPU] = clr_vec[t][s*NCPU +: NCPU]
                                    | req_wdata[k*8 +: NCPU];
                            end
                        end
                    end
                end
            end
        end
    end

    genvar gt;
    generate
        for (gt = 0; gt < NCPU; gt++) begin : g_bank
            sgi_source_bank #(
                .NCPU (NCPU)
            ) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .set_bits (set_vec[gt]),
                .clr_bits (clr_vec[gt]),
                .src_map  (bank_map[gt]),
                .pend     (bank_pend[gt])
            );

            assign sgi_pending[gt*NUM_SGI +: NUM_SGI] = bank_pend[gt];

            AST_OFFLINE_ROW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
                (req_valid && req_write && (view == VIEW_TRIG)
                 && (CNT_W'(gt) >= cpus_online))
                |=> $stable(sgi_pending[gt*NUM_SGI +: NUM_SGI])); // R6
        end
    endgenerate

    // Assemble read data from the requester's bitmaps
    always_comb begin : read_mux
        rd_next = '0;
        if ((view == VIEW_SET) || (view == VIEW_CLR)) begin
            for (int k = 0; k < LANES; k++) begin
                if (lane_en[k]) begin
                    rd_next[k*8 +: 8] = 8'(bank_map[req_cpu][
                        int'(lane_sgi[k*SGI_W +: SGI_W])*NCPU +: NCPU]);
                end
            end
        end
    end

    // Register the read response
    always_ff @(posedge clk) begin : rsp_reg
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= is_read;
            if (is_read) begin
                rsp_data <= rd_next;
            end
        end
    end

    AST_RSP_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        is_read |=> rsp_valid); // R12

    AST_TRIG_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (is_read && ((view == VIEW_TRIG) || (view == VIEW_NONE))) |=> (rsp_data == '0)); // R7

    AST_RESERVED_MODE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && (view == VIEW_TRIG) && (req_wdata[25:24] == 2'b11))
        |=> $stable(sgi_pending)); // R5

    AST_MODE1_SKIPS_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_wr && (req_wdata[25:24] == 2'b01)) |-> !tgt_mask[req_cpu]); // R3

    AST_MODE2_SOLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_wr && (req_wdata[25:24] == 2'b10))
        |-> ($countones(tgt_mask) <= 1)); // R4

endmodule

// File: tb/tb_sgi_dispatch.sv
// Bench for sgi_dispatch: a behavioural reference model updated on each rising
// edge and compared with the outputs on every falling edge.
module tb_sgi_dispatch;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   cpus_online = 4'd8;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic         req_wide = 1'b0;
    logic [5:0]   req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic [2:0]   req_cpu = '0;
    logic         rsp_valid;
    logic [31:0]  rsp_data;
    logic [127:0] sgi_pending;

    int unsigned srcm [8][16];
    bit          exp_rv;
    logic [31:0] exp_rd;
    int          vectors = 0;
    int          fails = 0;
    string       cur_req = "R1";
    bit          done = 1'b0;

    always #10 clk = ~clk;

    sgi_dispatch dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpus_online (cpus_online),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_wide    (req_wide),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .req_cpu     (req_cpu),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data),
        .sgi_pending (sgi_pending)
    );

    // Reference model, advanced on the same edge as the design
    always @(posedge clk) begin
        int unsigned tg, md, id, a, b;
        if (!rst_n) begin
            for (int t = 0; t < 8; t++) for (int s = 0; s < 16; s++) srcm[t][s] = 0;
            exp_rv = 0;
        end else begin
            exp_rv = req_valid && !req_write;
            if (req_valid && !req_write) begin
                exp_rd = 0;
                if (req_addr[5:4] == 2'd1 || req_addr[5:4] == 2'd2) begin
                    if (req_wide) begin
                        for (int k = 0; k < 4; k++)
                            exp_rd = exp_rd | (srcm[req_cpu][req_addr[3:2]*4 + k] << (8*k));
                    end else begin
                        exp_rd = srcm[req_cpu][req_addr[3:0]];
                    end
                end
            end
            if (req_valid && req_write && req_wide && req_addr[5:4] == 2'd0) begin
                md = (req_wdata >> 24) & 3;
                id = req_wdata & 15;
                case (md)
                    0: tg = (req_wdata >> 16) & 255;
                    1: tg = 255 & ~(1 << req_cpu);
                    2: tg = 1 << req_cpu;
                    default: tg = 0;
                endcase
                tg = tg & ((1 << cpus_online) - 1);
                for (int t = 0; t < 8; t++)
                    if ((tg >> t) & 1) srcm[t][id] = srcm[t][id] | (1 << req_cpu);
            end
            if (req_valid && req_write && (req_addr[5:4] == 2'd1 || req_addr[5:4] == 2'd2)) begin
                for (int k = 0; k < 4; k++) begin
                    if (req_wide || k == 0) begin
                        a = req_wide ? req_addr[3:2]*4 + k : req_addr[3:0];
                        b = (req_wdata >> (8*k)) & 255;
                        if (req_addr[5:4] == 2'd2) srcm[req_cpu][a] = srcm[req_cpu][a] | b;
                        else                       srcm[req_cpu][a] = srcm[req_cpu][a] & ~b;
                    end
                end
            end
        end
    end

    // Compare outputs against the model away from the active edge
    always @(negedge clk) begin
        logic [127:0] ep;
        if (!done) begin
            for (int t = 0; t < 8; t++)
                for (int s = 0; s < 16; s++) ep[t*16 + s] = (srcm[t][s] != 0);
            vectors++;
            if (sgi_pending !== ep) begin
                fails++;
                $display("FAIL %s (R11) sgi_pending actual %h expected %h", cur_req, sgi_pending, ep);
            end
            if (rsp_valid !== exp_rv) begin
                fails++;
                $display("FAIL %s (R12) rsp_valid actual %b expected %b", cur_req, rsp_valid, exp_rv);
            end else if (exp_rv && rsp_data !== exp_rd) begin
                fails++;
                $display("FAIL %s rsp_data actual %h expected %h", cur_req, rsp_data, exp_rd);
            end
        end
    end

    task automatic op(input bit wr, input bit wide, input logic [5:0] addr,
                      input logic [31:0] data, input logic [2:0] cpu);
        @(posedge clk); #2;
        req_valid = 1'b1; req_write = wr; req_wide = wide;
        req_addr = addr; req_wdata = data; req_cpu = cpu;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            req_valid = 1'b0;
        end
    endtask

    task automatic trig(input logic [2:0] cpu, input int mode, input int list, input int sgi);
        op(1, 1, 6'h00, 32'((mode << 24) | (list << 16) | sgi), cpu);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired in %s", cur_req);
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        cur_req = "R1";
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        idle(2);

        cur_req = "R2";
        trig(3'd1, 0, 8'h0D, 5);
        trig(3'd3, 0, 8'h01, 5);
        idle(1);
        for (int c = 0; c < 8; c++) op(0, 1, 6'h24, 0, 3'(c));
        idle(1);

        cur_req = "R3";
        trig(3'd2, 1, 8'h00, 3);
        idle(1);
        for (int c = 0; c < 8; c++) op(0, 0, 6'h13, 0, 3'(c));

        cur_req = "R4";
        trig(3'd6, 2, 8'hFF, 15);
        op(0, 1, 6'h2C, 0, 3'd6);
        idle(1);

        cur_req = "R5";
        trig(3'd0, 3, 8'hFF, 9);
        op(1, 0, 6'h00, 32'h00FF_0009, 3'd0);
        op(1, 1, 6'h30, 32'hFFFF_FFFF, 3'd0);
        op(0, 1, 6'h28, 0, 3'd0);
        idle(1);

        cur_req = "R7";
        op(0, 1, 6'h00, 0, 3'd1);
        op(0, 0, 6'h05, 0, 3'd1);
        op(0, 1, 6'h34, 0, 3'd1);
        idle(1);

        cur_req = "R8";
        op(0, 1, 6'h14, 0, 3'd0);
        op(0, 0, 6'h25, 0, 3'd3);
        op(0, 0, 6'h1F, 0, 3'd6);
        idle(1);

        cur_req = "R9";
        op(1, 1, 6'h28, 32'h8001_0042, 3'd4);
        op(1, 0, 6'h2F, 32'h0000_0011, 3'd4);
        op(0, 1, 6'h28, 0, 3'd4);
        op(0, 1, 6'h2C, 0, 3'd4);
        idle(1);

        cur_req = "R10";
        op(1, 0, 6'h1A, 32'h0000_0040, 3'd4);
        op(1, 1, 6'h18, 32'hFFFF_FFFF, 3'd4);
        op(1, 0, 6'h1F, 32'h0000_00FF, 3'd4);
        op(0, 1, 6'h2C, 0, 3'd4);
        op(1, 1, 6'h14, 32'h0000_0002, 3'd0);
        op(0, 1, 6'h24, 0, 3'd0);
        idle(1);

        cur_req = "R6";
        cpus_online = 4'd5;
        trig(3'd0, 0, 8'hFF, 7);
        trig(3'd1, 1, 8'h00, 8);
        trig(3'd6, 2, 8'h00, 10);
        op(0, 1, 6'h24, 0, 3'd5);
        op(0, 1, 6'h24, 0, 3'd4);
        idle(1);
        cpus_online = 4'd8;

        cur_req = "R11";
        for (int i = 0; i < 600; i++) begin
            int unsigned r;
            r = $urandom;
            if (i % 97 == 0) begin
                idle(1);
                cpus_online = 4'(1 + ($urandom % 8));
            end
            op(r[0], r[1], 6'(r[7:2]), $urandom, 3'(r[10:8]));
        end
        idle(1);
        cpus_online = 4'd8;

        cur_req = "R12";
        for (int c = 0; c < 8; c++)
            for (int w = 0; w < 4; w++) op(0, 1, 6'(6'h10 + 4*w), 0, 3'(c));
        idle(2);

        cur_req = "R1";
        @(posedge clk); #2 rst_n = 1'b0;
        idle(2);
        #2 rst_n = 1'b1;
        idle(2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule